// File: doc/BRIEF.md
# Serial Flash Status Register Controller

This block implements the status register of a serial flash slave that sits on an SPI bus. It recognises three one-byte instructions: one arms writes, one loads a new status value, and one streams the status byte back to the host. Writes to the status register must be armed first and must be framed exactly. They pass through a fixed writable-bit mask, and they can be locked by a protect bit combined with an active-low write-protect pin. Each write that is accepted starts a self-timed busy period. During that period the host can poll the busy flag through the read instruction, and every other instruction is dropped.

The SPI pins are brought into the system clock domain through two-flop synchronisers. All sequencing is done by one state machine clocked by the system clock. SCK must therefore be slower than a quarter of the system clock. The block-protect field is only stored and presented on an output for the array logic elsewhere. The parameter `WIDE_MAP` selects between a four-bit writable mask and a three-bit writable mask.

State machine states:
- IDLE: CS is deasserted.
- OPCODE: collecting the instruction byte.
- WRDATA: collecting the status data byte.
- WRHOLD: a full data byte has arrived and the block waits for CS to rise.
- WENHOLD: an arm opcode has arrived and the block waits for CS to rise.
- RDOUT: streaming the status byte.
- DROP: discarding clocks until CS rises.

State machine transitions:
- IDLE→OPCODE on a CS fall.
- OPCODE→RDOUT, WENHOLD, WRDATA or DROP when the eighth bit arrives, chosen by the decoded opcode and the permissions.
- WRDATA→WRHOLD on the eighth data bit.
- WRHOLD or WENHOLD→DROP on any further SCK rise.
- Any state→IDLE on a CS rise. From WRHOLD this rise commits the write; from WENHOLD it sets the enable flag.

Top module: `sfsr_ctrl`

## Requirements
- R1: After reset the status byte reads 0x00, the block-protect output is 0 and the DO enable is low.
- R2: Opcode 0x06, followed by CS rising right after its eighth bit, sets the write-enable flag (status bit 1). If any extra bit is clocked before CS rises, the flag is not set. SPI mode 0 and mode 3 both work, with DI sampled on SCK rising edges.
- R3: Opcode 0x01 followed by one data byte, sent MSB first, writes the status register through the mask. With WIDE_MAP=1, bits 7, 4, 3 and 2 are writable. With WIDE_MAP=0, bits 7, 3 and 2 are writable. All other bits keep their value, and bits 6 and 5 read 0.
- R4: A 0x01 instruction issued while the enable flag is 0 changes nothing.
- R5: The write commits only if CS rises directly after the eighth data bit. With seven or nine data bits the instruction is discarded and the enable flag keeps its value.
- R6: A committed write raises the busy flag (status bit 0) for exactly TW_CYCLES system clocks. The enable flag is cleared in the same cycle that busy rises.
- R7: Opcode 0x05 shifts the live status byte out MSB first, one bit per SCK falling edge. The byte repeats while CS stays low, and the instruction works while busy is 1.
- R8: While busy is 1, any instruction other than 0x05 is ignored.
- R9: When bit 7 (protect) is 1 and the write-protect pin is low, 0x01 is ignored. When the pin is high, 0x01 is accepted. When bit 7 is 0, the pin has no effect.
- R10: The DO enable is high only during a read-out. `bp_o` mirrors status bits 4..2.
- R11: An unknown opcode is ignored until CS rises. It leaves the status unchanged and does not enable DO.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | SPI serial clock |
| spi_di | input | 1 | Serial data from host |
| spi_wp_n | input | 1 | Write-protect pin, active low |
| spi_do | output | 1 | Serial data to host |
| spi_do_oe | output | 1 | Pad driver enable for spi_do (high impedance when 0) |
| sts_o | output | 8 | Current status byte |
| bp_o | output | 3 | Stored block-protect field (status bits 4..2) |

## Verification
Every pin event reaches the state machine on the third system clock edge after the edge that first samples it. A CS rise therefore updates `sts_o` three clocks later, and a DO bit settles three clocks after the SCK fall that shifts it. Busy then stays high for exactly TW_CYCLES clocks. The bench holds every SCK phase for six clocks and samples DO at the end of the phase. It waits at least eight clocks after CS rises before reading the status. It measures the busy length by counting clocks on the falling edge, and it places its busy-time reads and arm attempts well inside the TW_CYCLES window.

// File: rtl/sfsr_pkg.sv
package sfsr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPCODE,
        ST_WRDATA,
        ST_WRHOLD,
        ST_WENHOLD,
        ST_RDOUT,
        ST_DROP
    } sfsr_state_e;

    localparam logic [7:0] OP_ARM   = 8'h06;
    localparam logic [7:0] OP_WRITE = 8'h01;
    localparam logic [7:0] OP_READ  = 8'h05;

    localparam int SYNC_W  = 4;
    localparam int PIN_CS  = 0;
    localparam int PIN_SCK = 1;
    localparam int PIN_DI  = 2;
    localparam int PIN_WP  = 3;

    function automatic logic [7:0] writable_mask(input bit wide);
        return wide ? 8'h9C : 8'h8C;
    endfunction

endpackage

// File: rtl/sfsr_pin_sync.sv
module sfsr_pin_sync #(
    parameter int               W       = 4,
    parameter int               STAGES  = 2,
    parameter logic [W-1:0]     RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);

    logic [W-1:0] stg [0:STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i <= STAGES; i++) stg[i] <= RST_VAL;
        end else begin
            stg[0] <= pin_i;
            for (int i = 1; i <= STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign lvl_o  = stg[STAGES-1];
    assign rise_o = stg[STAGES-1] & ~stg[STAGES];
    assign fall_o = ~stg[STAGES-1] & stg[STAGES];

endmodule

// File: rtl/sfsr_rx_shift.sv
module sfsr_rx_shift #(
    parameter int WORD = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clr_i,
    input  logic            shift_i,
    input  logic            bit_i,
    output logic            done_o,
    output logic [WORD-1:0] word_o
);

    localparam int CW = (WORD > 1) ? $clog2(WORD) : 1;

    logic [WORD-1:0] sh_q;
    logic [CW-1:0]   cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            cnt_q  <= '0;
            done_o <= 1'b0;
            word_o <= '0;
        end else if (clr_i) begin
            cnt_q  <= '0;
            done_o <= 1'b0;
        end else begin
            done_o <= 1'b0;
            if (shift_i) begin
                sh_q <= {sh_q[WORD-2:0], bit_i};
                if (cnt_q == CW'(WORD - 1)) begin
                    cnt_q  <= '0;
                    done_o <= 1'b1;
                    word_o <= {sh_q[WORD-2:0], bit_i};
                end else begin
                    cnt_q <= cnt_q + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/sfsr_wcycle_timer.sv
module sfsr_wcycle_timer #(
    parameter int TW_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);

    localparam int CW = $clog2(TW_CYCLES + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              cnt_q <= '0;
        else if (start_i)        cnt_q <= CW'(TW_CYCLES);
        else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
    end

    assign busy_o = (cnt_q != '0);

endmodule

// File: rtl/sfsr_ctrl.sv
module sfsr_ctrl
    import sfsr_pkg::*;
#(
    parameter bit WIDE_MAP  = 1'b1,
    parameter int TW_CYCLES = 1000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       spi_cs_n,
    input  logic       spi_sck,
    input  logic       spi_di,
    input  logic       spi_wp_n,
    output logic       spi_do,
    output logic       spi_do_oe,
    output logic [7:0] sts_o,
    output logic [2:0] bp_o
);

    localparam logic [7:0] WMASK   = writable_mask(WIDE_MAP);
    localparam logic [5:0] NV_MASK = WMASK[7:2];

    // Pin synchronisation and edge detection
    logic [SYNC_W-1:0] pin_lvl, pin_rise, pin_fall;

    sfsr_pin_sync #(
        .W       (SYNC_W),
        .STAGES  (2),
        .RST_VAL (4'b1001)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  ({spi_wp_n, spi_di, spi_sck, spi_cs_n}),
        .lvl_o  (pin_lvl),
        .rise_o (pin_rise),
        .fall_o (pin_fall)
    );

    logic cs_hi, cs_rise, cs_fall, sck_rise, sck_fall, di_s, wp_hi;
    assign cs_hi    = pin_lvl[PIN_CS];
    assign cs_rise  = pin_rise[PIN_CS];
    assign cs_fall  = pin_fall[PIN_CS];
    assign sck_rise = pin_rise[PIN_SCK];
    assign sck_fall = pin_fall[PIN_SCK];
    assign di_s     = pin_lvl[PIN_DI];
    assign wp_hi    = pin_lvl[PIN_WP];

    logic sync_unused;
    assign sync_unused = ^{pin_lvl[PIN_SCK], pin_rise[PIN_DI], pin_fall[PIN_DI],
                           pin_rise[PIN_WP], pin_fall[PIN_WP]};

    // Byte receiver
    logic       rx_done;
    logic [7:0] rx_word;

    sfsr_rx_shift #(.WORD(8)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (cs_hi),
        .shift_i (sck_rise),
        .bit_i   (di_s),
        .done_o  (rx_done),
        .word_o  (rx_word)
    );

    // Self-timed write cycle
    logic busy, commit_wr, set_wel;

    sfsr_wcycle_timer #(.TW_CYCLES(TW_CYCLES)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (commit_wr),
        .busy_o  (busy)
    );

    // Status storage
    logic [7:2] nv_q;
    logic       wel_q;
    logic [7:0] status;
    assign status = {nv_q, wel_q, busy};

    // Permission decode
    logic arm_ok, wr_ok, locked;
    assign locked = nv_q[7] && !wp_hi;
    assign arm_ok = (rx_word == OP_ARM) && !busy;
    assign wr_ok  = (rx_word == OP_WRITE) && !busy && wel_q && !locked;

    // State register
    sfsr_state_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (cs_rise) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_IDLE:    if (cs_fall) st_d = ST_OPCODE;
                ST_OPCODE: begin
                    if (rx_done) begin
                        if (rx_word == OP_READ) st_d = ST_RDOUT;
                        else if (arm_ok)        st_d = ST_WENHOLD;
                        else if (wr_ok)         st_d = ST_WRDATA;
                        else                    st_d = ST_DROP;
                    end
                end
                ST_WRDATA:  if (rx_done)  st_d = ST_WRHOLD;
                ST_WRHOLD:  if (sck_rise) st_d = ST_DROP;
                ST_WENHOLD: if (sck_rise) st_d = ST_DROP;
                ST_RDOUT:   st_d = ST_RDOUT;
                ST_DROP:    st_d = ST_DROP;
                default:    st_d = ST_IDLE;
            endcase
        end
    end

    assign commit_wr = cs_rise && (st_q == ST_WRHOLD);
    assign set_wel   = cs_rise && (st_q == ST_WENHOLD);

    // Outputs and datapath
    logic [7:0] wdata_q;
    logic [7:0] rd_sh_q;
    logic [2:0] rd_cnt_q;
    logic       do_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nv_q     <= '0;
            wel_q    <= 1'b0;
            wdata_q  <= '0;
            rd_sh_q  <= '0;
            rd_cnt_q <= '0;
            do_q     <= 1'b0;
        end else begin
            if (commit_wr) begin
                nv_q  <= (nv_q & ~NV_MASK) | (wdata_q[7:2] & NV_MASK);
                wel_q <= 1'b0;
            end else if (set_wel) begin
                wel_q <= 1'b1;
            end

            if (st_q == ST_WRDATA && rx_done) wdata_q <= rx_word;

            if (st_q == ST_OPCODE && rx_done && rx_word == OP_READ) begin
                rd_sh_q  <= status;
                rd_cnt_q <= '0;
            end else if (st_q == ST_RDOUT && sck_fall) begin
                do_q <= rd_sh_q[7];
                if (rd_cnt_q == 3'd7) begin
                    rd_sh_q  <= status;
                    rd_cnt_q <= '0;
                end else begin
                    rd_sh_q  <= {rd_sh_q[6:0], 1'b0};
                    rd_cnt_q <= rd_cnt_q + 1'b1;
                end
            end
        end
    end

    assign spi_do_oe = (st_q == ST_RDOUT);
    assign spi_do    = spi_do_oe ? do_q : 1'b0;
    assign sts_o     = status;
    assign bp_o      = nv_q[4:2];

endmodule

// File: rtl/sfsr_chk.sv
module sfsr_chk #(
    parameter int TW_CYCLES = 1000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       spi_cs_n,
    input logic       spi_do_oe,
    input logic [7:0] sts_o
);

    int unsigned busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        busy_run <= 0;
        else if (sts_o[0]) busy_run <= busy_run + 1;
        else               busy_run <= 0;
    end

    // R6: enable flag is clear once the busy period starts
    p_wel_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_o[0]) |-> !sts_o[1]);

    // R6: busy period length
    p_busy_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sts_o[0]) |-> (busy_run == TW_CYCLES));

    // R4: a write needs the enable flag beforehand
    p_busy_needs_wel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_o[0]) |-> $past(sts_o[1]));

    // R8: the enable flag is never set during busy
    p_no_arm_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sts_o[1]) |-> !sts_o[0]);

    // R3: stored bits change only when a write cycle starts
    p_nv_change_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_o[7:2] != $past(sts_o[7:2])) |-> $rose(sts_o[0]));

    // R10: DO not driven once CS has stayed high
    p_oe_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (spi_cs_n && $past(spi_cs_n) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3))
        |-> !spi_do_oe);

endmodule

bind sfsr_ctrl sfsr_chk #(.TW_CYCLES(TW_CYCLES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .spi_cs_n  (spi_cs_n),
    .spi_do_oe (spi_do_oe),
    .sts_o     (sts_o)
);

// File: tb/sfsr_ctrl_tb_top.sv
module sfsr_ctrl_tb_top;

    localparam int TW = 500;
    localparam int HP = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs_n = 1'b1, sck = 1'b0, di = 1'b0, wp_n = 1'b1;
    logic do_i, oe_i, do_s, oe_s;
    logic [7:0] sts_i, sts_s;
    logic [2:0] bp_i, bp_s;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    sfsr_ctrl #(.WIDE_MAP(1'b1), .TW_CYCLES(TW)) dut_i (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_di(di),
        .spi_wp_n(wp_n), .spi_do(do_i), .spi_do_oe(oe_i), .sts_o(sts_i), .bp_o(bp_i));

    sfsr_ctrl #(.WIDE_MAP(1'b0), .TW_CYCLES(TW)) dut_s (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sck(sck), .spi_di(di),
        .spi_wp_n(wp_n), .spi_do(do_s), .spi_do_oe(oe_s), .sts_o(sts_s), .bp_o(bp_s));

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=0x%0h exp=0x%0h", req, act, exp);
        end
    endtask

    task automatic spi_send(input logic [23:0] bits, input int n, input bit m3);
        sck = m3;
        tick(HP);
        cs_n = 1'b0;
        tick(HP);
        for (int k = n - 1; k >= 0; k--) begin
            if (m3) sck = 1'b0;
            di = bits[k];
            tick(HP);
            sck = 1'b1;
            tick(HP);
            if (!m3) sck = 1'b0;
        end
        tick(HP);
        cs_n = 1'b1;
    endtask

    task automatic rd_status(input int nbytes, input logic [7:0] exp_i,
                             input logic [7:0] exp_s, input string req);
        logic [7:0] got_i, got_s;
        sck = 1'b0;
        tick(HP);
        cs_n = 1'b0;
        tick(HP);
        for (int k = 7; k >= 0; k--) begin
            di = OP_RD[k];
            tick(HP);
            sck = 1'b1;
            tick(HP);
            sck = 1'b0;
        end
        for (int b = 0; b < nbytes; b++) begin
            for (int k = 7; k >= 0; k--) begin
                tick(HP);
                got_i[k] = do_i;
                got_s[k] = do_s;
                sck = 1'b1;
                tick(HP);
                sck = 1'b0;
            end
            chk({req, " read wide"}, got_i, exp_i);
            chk({req, " read narrow"}, got_s, exp_s);
            chk("R10 oe during read", oe_i, 1'b1);
        end
        tick(HP);
        cs_n = 1'b1;
        tick(8);
    endtask

    localparam logic [7:0] OP_RD = 8'h05;

    // R1: reset state
    task automatic t_reset();
        chk("R1 status wide", sts_i, 8'h00);
        chk("R1 status narrow", sts_s, 8'h00);
        chk("R1 bp", bp_i, 3'd0);
        chk("R1 oe", oe_i, 1'b0);
    endtask

    // R4: write without enable
    task automatic t_no_wel();
        spi_send(24'h01FF, 16, 1'b0);
        tick(10);
        chk("R4 status unchanged", sts_i, 8'h00);
        chk("R4 no busy", sts_s, 8'h00);
    endtask

    // R2/R7: arm then read back
    task automatic t_arm();
        spi_send(24'h06, 8, 1'b0);
        tick(10);
        chk("R2 wel set", sts_i, 8'h02);
        rd_status(1, 8'h02, 8'h02, "R7");
        chk("R10 oe after read", oe_i, 1'b0);
    endtask

    // R6/R3/R10: committed write and busy length
    task automatic t_write_ff();
        int cnt = 0;
        spi_send(24'h01FF, 16, 1'b0);
        for (int c = 0; c < TW + 40; c++) begin
            tick(1);
            if (sts_i[0]) cnt++;
            if (c == 10) begin
                chk("R6 busy during cycle", sts_i[0], 1'b1);
                chk("R6 wel cleared", sts_i[1], 1'b0);
            end
        end
        chk("R6 busy length", cnt, TW);
        chk("R3 wide mask", sts_i, 8'h9C);
        chk("R3 narrow mask", sts_s, 8'h8C);
        chk("R10 bp wide", bp_i, 3'd7);
        chk("R10 bp narrow", bp_s, 3'd3);
    endtask

    // R5: framing errors
    task automatic t_framing();
        spi_send(24'h06, 8, 1'b0);
        tick(10);
        spi_send(24'h000080, 15, 1'b0);
        tick(10);
        chk("R5 seven bits ignored", sts_i, 8'h9E);
        spi_send(24'h000200, 17, 1'b0);
        tick(10);
        chk("R5 nine bits ignored wide", sts_i, 8'h9E);
        chk("R5 nine bits ignored narrow", sts_s, 8'h8E);
    endtask

    // R9: protect bit with WP pin
    task automatic t_protect();
        wp_n = 1'b0;
        tick(4);
        spi_send(24'h0100, 16, 1'b0);
        tick(10);
        chk("R9 locked while pin low", sts_i, 8'h9E);
        wp_n = 1'b1;
        tick(4);
        spi_send(24'h0100, 16, 1'b0);
        tick(TW + 20);
        chk("R9 allowed while pin high", sts_i, 8'h00);
        wp_n = 1'b0;
        tick(4);
        spi_send(24'h06, 8, 1'b0);
        tick(10);
        spi_send(24'h0110, 16, 1'b0);
        tick(TW + 20);
        chk("R9 pin ignored when protect clear", sts_i, 8'h10);
        chk("R3 bit4 read-only narrow", sts_s, 8'h00);
        wp_n = 1'b1;
        tick(4);
    endtask

    // R7/R8: activity during busy
    task automatic t_busy_activity();
        spi_send(24'h06, 8, 1'b0);
        tick(10);
        chk("R2 wel set again", sts_i, 8'h12);
        spi_send(24'h010C, 16, 1'b0);
        tick(8);
        rd_status(1, 8'h0D, 8'h0D, "R7 poll busy");
        chk("R8 still busy", sts_i[0], 1'b1);
        spi_send(24'h06, 8, 1'b0);
        tick(10);
        chk("R8 arm ignored while busy", sts_i[1], 1'b0);
        tick(TW);
        chk("R8 after busy wide", sts_i, 8'h0C);
        chk("R8 after busy narrow", sts_s, 8'h0C);
    endtask

    // R11: unknown opcode
    task automatic t_unknown();
        logic saw_oe = 1'b0;
        fork
            spi_send(24'h9F00, 16, 1'b0);
            begin
                for (int c = 0; c < 16 * 2 * HP + 3 * HP; c++) begin
                    tick(1);
                    if (oe_i) saw_oe = 1'b1;
                end
            end
        join
        tick(10);
        chk("R11 no DO enable", saw_oe, 1'b0);
        chk("R11 status unchanged", sts_i, 8'h0C);
        rd_status(1, 8'h0C, 8'h0C, "R11 recovery");
    endtask

    // R2: over-long arm, then mode 3 arm
    task automatic t_mode3();
        spi_send(24'h00C, 9, 1'b0);
        tick(10);
        chk("R2 nine-bit arm ignored", sts_i, 8'h0C);
        spi_send(24'h06, 8, 1'b1);
        tick(10);
        chk("R2 mode 3 arm", sts_i, 8'h0E);
        rd_status(2, 8'h0E, 8'h0E, "R7 repeat");
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_no_wel();
        t_arm();
        t_write_ff();
        t_framing();
        t_protect();
        t_busy_activity();
        t_unknown();
        t_mode3();
        if (!finished) begin
            finished = 1'b1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog all act=timeout exp=completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule